// File: doc/BRIEF.md
# Register-List Stack Transfer Sequencer

This block carries out multi-register stack saves and restores selected by an 8-bit register-list mask. A one-cycle start pulse loads the direction (save or restore), the transfer size (16-bit registers or 8-bit register halves), a bank bit, the mask and the current stack pointer. The block then moves one register per clock through a simple memory port and a register-file port. Both ports have combinational read data.

A save visits the set mask bits from the most significant down. For each one it lowers the stack pointer by two and writes the register to that address. A restore visits the set bits from the least significant up. For each one it reads the stack word at the pointer, writes it to the register, and then raises the pointer by two. Every entry takes one 16-bit stack slot, even in byte mode.

Clear mask bits cost no cycle, because a priority encoder picks the next set bit each clock. When the walk ends, the final stack pointer appears on `sp_o` and `done_o` pulses for one cycle.

Top module: `rls_seq`

## Requirements
- R1: A save (`pop_i`=0) visits set mask bits from bit 7 down to bit 0. For each one it drives `mem_we_o`=1 at address (pointer − 2), with the register's data on `mem_wdata_o`, and this value becomes the new pointer.
- R2: A restore (`pop_i`=1) visits set mask bits from bit 0 up to bit 7. For each one it drives `mem_re_o`=1 and `rf_we_o`=1 at the current pointer address, and then adds 2 to the pointer.
- R3: The pointer moves by exactly 2 per transferred register in both sizes. `sp_o` takes the final value (start pointer minus 2·n for a save, plus 2·n for a restore, where n is the number of set bits) in the cycle `done_o` is high, and holds it afterwards.
- R4: Mask bit i addresses register i+8 on `rf_idx_o` when `bank_i`=1, and register i when `bank_i`=0.
- R5: `rf_word_o` equals the latched `word_i`. With `word_i`=0 (byte mode), a save writes {8'h00, low byte of `rf_rdata_i`} to memory, and a restore writes {8'h00, low byte of `mem_rdata_i`} to the register. With `word_i`=1, all 16 bits pass unchanged.
- R6: Each cycle while `busy_o` is high performs exactly one transfer. For n ≥ 1 set bits, `done_o` rises n clock edges after the edge that accepted the start.
- R7: A zero mask raises `done_o` one edge after the start, with `sp_o` equal to the start pointer and no memory or register strobe.
- R8: `done_o` is a one-cycle pulse and is never high while `busy_o` is high. A start while `busy_o` is high is ignored.
- R9: After reset `busy_o`, `done_o`, all strobes and `sp_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when not busy |
| pop_i | input | 1 | 1 = restore from stack, 0 = save to stack |
| word_i | input | 1 | 1 = 16-bit registers, 0 = 8-bit halves |
| bank_i | input | 1 | Selects registers 8..15 when set |
| mask_i | input | 8 | Register-list mask |
| sp_i | input | 16 | Stack pointer at start |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| mem_rdata_i | input | 16 | Memory read data, same cycle |
| rf_idx_o | output | 4 | Register index |
| rf_word_o | output | 1 | Register access width, 1 = 16 bits |
| rf_rdata_i | input | 16 | Register read data, same cycle |
| rf_wdata_o | output | 16 | Register write data |
| rf_we_o | output | 1 | Register write strobe |
| sp_o | output | 16 | Final stack pointer |
| done_o | output | 1 | End-of-sequence pulse |
| busy_o | output | 1 | Sequence in progress |

## Verification
The step properties assume that no new sequence begins in the same cycle as the previous one's last transfer. This holds because a start is only taken while idle, and the idle cycle with `done_o` high separates two runs. The properties also assume that the stack pointer does not wrap past zero or the top of the address space within one run. The stimulus draws start pointers from a window well inside the bench memory, so eight saves or restores never cross its ends. It also only pulses a second start during runs that have at least two transfers left.

// File: rtl/rls_pkg.sv
package rls_pkg;
    localparam int LIST_W_DEF = 8;
    localparam int ADDR_W_DEF = 16;
    localparam int DATA_W_DEF = 16;
    localparam int STEP_DEF   = 2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } rls_state_e;
endpackage

// File: rtl/rls_pick.sv
module rls_pick #(
    parameter int W          = 8,
    parameter bit HIGH_FIRST = 1'b1,
    localparam int POS_W     = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]     vec_i,
    output logic             any_o,
    output logic [POS_W-1:0] pos_o,
    output logic [W-1:0]     hot_o
);
    assign any_o = |vec_i;
    assign hot_o = any_o ? (W'(1) << pos_o) : '0;

    generate
        if (HIGH_FIRST) begin : g_high
            always_comb begin
                pos_o = '0;
                for (int i = 0; i < W; i++) begin
                    if (vec_i[i]) pos_o = POS_W'(i);
                end
            end
        end else begin : g_low
            always_comb begin
                pos_o = '0;
                for (int i = W - 1; i >= 0; i--) begin
                    if (vec_i[i]) pos_o = POS_W'(i);
                end
            end
        end
    endgenerate
endmodule

// File: rtl/rls_lane.sv
module rls_lane #(
    parameter int DATA_W    = 16,
    localparam int HALF_W   = DATA_W / 2
) (
    input  logic              word_i,
    input  logic [DATA_W-1:0] rf_rdata_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic [DATA_W-1:0] rf_wdata_o
);
    always_comb begin
        if (word_i) begin
            mem_wdata_o = rf_rdata_i;
            rf_wdata_o  = mem_rdata_i;
        end else begin
            mem_wdata_o = {{(DATA_W-HALF_W){1'b0}}, rf_rdata_i[HALF_W-1:0]};
            rf_wdata_o  = {{(DATA_W-HALF_W){1'b0}}, mem_rdata_i[HALF_W-1:0]};
        end
    end
endmodule

// File: rtl/rls_seq.sv
module rls_seq
    import rls_pkg::*;
#(
    parameter int LIST_W   = LIST_W_DEF,
    parameter int ADDR_W   = ADDR_W_DEF,
    parameter int DATA_W   = DATA_W_DEF,
    parameter int STEP     = STEP_DEF,
    localparam int POS_W   = (LIST_W > 1) ? $clog2(LIST_W) : 1,
    localparam int REG_W   = POS_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              pop_i,
    input  logic              word_i,
    input  logic              bank_i,
    input  logic [LIST_W-1:0] mask_i,
    input  logic [ADDR_W-1:0] sp_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              mem_we_o,
    output logic              mem_re_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [REG_W-1:0]  rf_idx_o,
    output logic              rf_word_o,
    input  logic [DATA_W-1:0] rf_rdata_i,
    output logic [DATA_W-1:0] rf_wdata_o,
    output logic              rf_we_o,
    output logic [ADDR_W-1:0] sp_o,
    output logic              done_o,
    output logic              busy_o
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    typedef struct packed {
        rls_state_e        st;
        logic [LIST_W-1:0] rem;
        logic [ADDR_W-1:0] sp;
        logic              pop;
        logic              word;
        logic              bank;
        logic              done;
        logic [ADDR_W-1:0] sp_out;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              hi_any, lo_any;
    logic [POS_W-1:0]  hi_pos, lo_pos;
    logic [LIST_W-1:0] hi_hot, lo_hot;
    logic [POS_W-1:0]  sel_pos;
    logic [LIST_W-1:0] sel_hot;
    logic              run;
    logic [DATA_W-1:0] lane_mem_wdata, lane_rf_wdata;

    // Save walks downward, restore walks upward
    rls_pick #(.W(LIST_W), .HIGH_FIRST(1'b1)) u_pick_hi (
        .vec_i (ctl_q.rem),
        .any_o (hi_any),
        .pos_o (hi_pos),
        .hot_o (hi_hot)
    );

    rls_pick #(.W(LIST_W), .HIGH_FIRST(1'b0)) u_pick_lo (
        .vec_i (ctl_q.rem),
        .any_o (lo_any),
        .pos_o (lo_pos),
        .hot_o (lo_hot)
    );

    rls_lane #(.DATA_W(DATA_W)) u_lane (
        .word_i      (ctl_q.word),
        .rf_rdata_i  (rf_rdata_i),
        .mem_rdata_i (mem_rdata_i),
        .mem_wdata_o (lane_mem_wdata),
        .rf_wdata_o  (lane_rf_wdata)
    );

    assign sel_pos = ctl_q.pop ? lo_pos : hi_pos;
    assign sel_hot = ctl_q.pop ? lo_hot : hi_hot;
    assign run     = (ctl_q.st == ST_RUN) && (ctl_q.pop ? lo_any : hi_any);

    // Next-state computation
    always_comb begin
        logic [LIST_W-1:0] rem_nx;
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        rem_nx     = ctl_q.rem & ~sel_hot;
        case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.pop  = pop_i;
                    ctl_d.word = word_i;
                    ctl_d.bank = bank_i;
                    ctl_d.sp   = sp_i;
                    ctl_d.rem  = mask_i;
                    if (mask_i == '0) begin
                        ctl_d.done   = 1'b1;
                        ctl_d.sp_out = sp_i;
                    end else begin
                        ctl_d.st = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                ctl_d.rem = rem_nx;
                ctl_d.sp  = ctl_q.pop ? (ctl_q.sp + STEP_V) : (ctl_q.sp - STEP_V);
                if (rem_nx == '0) begin
                    ctl_d.st     = ST_IDLE;
                    ctl_d.done   = 1'b1;
                    ctl_d.sp_out = ctl_d.sp;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // Transaction outputs
    always_comb begin
        mem_addr_o  = ctl_q.pop ? ctl_q.sp : (ctl_q.sp - STEP_V);
        mem_wdata_o = lane_mem_wdata;
        rf_wdata_o  = lane_rf_wdata;
        mem_we_o    = run && !ctl_q.pop;
        mem_re_o    = run &&  ctl_q.pop;
        rf_we_o     = run &&  ctl_q.pop;
        rf_idx_o    = {ctl_q.bank, sel_pos};
        rf_word_o   = ctl_q.word;
    end

    assign sp_o   = ctl_q.sp_out;
    assign done_o = ctl_q.done;
    assign busy_o = (ctl_q.st == ST_RUN);
endmodule

// File: rtl/rls_seq_chk.sv
module rls_seq_chk #(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    localparam int HALF_W = DATA_W / 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [DATA_W-1:0] mem_wdata_o,
    input logic              mem_we_o,
    input logic              mem_re_o,
    input logic              rf_word_o,
    input logic [DATA_W-1:0] rf_wdata_o,
    input logic              rf_we_o,
    input logic              done_o,
    input logic              busy_o
);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !(mem_we_o || mem_re_o || rf_we_o));

    // R6
    one_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (mem_we_o ^ mem_re_o));

    // R2
    pop_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re_o |-> rf_we_o);

    // R1
    push_no_rf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> !rf_we_o);

    // R1
    push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && $past(mem_we_o) && $past(busy_o) && busy_o)
        |-> (mem_addr_o == $past(mem_addr_o) - ADDR_W'(2)));

    // R2
    pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re_o && $past(mem_re_o) && $past(busy_o) && busy_o)
        |-> (mem_addr_o == $past(mem_addr_o) + ADDR_W'(2)));

    // R5
    byte_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && !rf_word_o) |-> (mem_wdata_o[DATA_W-1:HALF_W] == '0));

    // R5
    byte_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we_o && !rf_word_o) |-> (rf_wdata_o[DATA_W-1:HALF_W] == '0));
endmodule

bind rls_seq rls_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_rls_seq.sv
module sim_rls_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, pop_i = 1'b0, word_i = 1'b0, bank_i = 1'b0;
    logic [7:0]  mask_i = '0;
    logic [15:0] sp_i = '0;
    logic [15:0] mem_addr_o, mem_wdata_o, mem_rdata_i, rf_rdata_i, rf_wdata_o, sp_o;
    logic        mem_we_o, mem_re_o, rf_word_o, rf_we_o, done_o, busy_o;
    logic [3:0]  rf_idx_o;

    logic [15:0] bmem [0:255];
    logic [15:0] wreg [0:15];
    logic [7:0]  breg [0:15];

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    rls_seq u0 (.*);

    assign mem_rdata_i = bmem[mem_addr_o[8:1]];
    assign rf_rdata_i  = rf_word_o ? wreg[rf_idx_o] : {8'hA5, breg[rf_idx_o]};

    always @(posedge clk) begin
        if (mem_we_o) bmem[mem_addr_o[8:1]] <= mem_wdata_o;
        if (rf_we_o) begin
            if (rf_word_o) wreg[rf_idx_o] <= rf_wdata_o;
            else           breg[rf_idx_o] <= rf_wdata_o[7:0];
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input bit pop, input bit word, input bit bank,
                          input logic [7:0] mask, input logic [15:0] sp,
                          input bit restart);
        int          n;
        logic [3:0]  e_idx  [8];
        logic [15:0] e_addr [8];
        logic [15:0] cur;
        logic [15:0] e_data;
        n   = 0;
        cur = sp;
        if (!pop) begin
            for (int b = 7; b >= 0; b--) begin
                if (mask[b]) begin
                    cur = cur - 16'd2;
                    e_idx[n] = {bank, 3'(b)}; e_addr[n] = cur; n++;
                end
            end
        end else begin
            for (int b = 0; b < 8; b++) begin
                if (mask[b]) begin
                    e_idx[n] = {bank, 3'(b)}; e_addr[n] = cur; n++;
                    cur = cur + 16'd2;
                end
            end
        end
        @(negedge clk);
        start_i = 1'b1; pop_i = pop; word_i = word; bank_i = bank;
        mask_i = mask; sp_i = sp;
        @(negedge clk);
        start_i = 1'b0;
        if (n == 0) begin
            chk(done_o == 1'b1, "R7", "empty done", 32'(done_o), 1);
            chk(sp_o == sp, "R7", "empty sp", 32'(sp_o), 32'(sp));
            chk(!(mem_we_o || mem_re_o || rf_we_o), "R7", "empty strobes",
                32'({mem_we_o, mem_re_o, rf_we_o}), 0);
        end else begin
            for (int k = 0; k < n; k++) begin
                if (restart && k == 0) begin
                    start_i = 1'b1; mask_i = 8'hFF; pop_i = ~pop; sp_i = 16'h0100;
                end else begin
                    start_i = 1'b0;
                end
                chk(busy_o && !done_o, "R6", "busy during walk", 32'({busy_o, done_o}), 2);
                chk(mem_addr_o == e_addr[k], pop ? "R2" : "R1", "address",
                    32'(mem_addr_o), 32'(e_addr[k]));
                chk(rf_idx_o == e_idx[k], "R4", "register index",
                    32'(rf_idx_o), 32'(e_idx[k]));
                chk(rf_word_o == word, "R5", "size", 32'(rf_word_o), 32'(word));
                if (!pop) begin
                    e_data = word ? wreg[e_idx[k]] : {8'h00, breg[e_idx[k]]};
                    chk(mem_we_o && !rf_we_o, "R1", "save strobes",
                        32'({mem_we_o, rf_we_o}), 2);
                    chk(mem_wdata_o == e_data, "R5", "save data",
                        32'(mem_wdata_o), 32'(e_data));
                end else begin
                    e_data = word ? bmem[e_addr[k][8:1]] : {8'h00, bmem[e_addr[k][8:1]][7:0]};
                    chk(mem_re_o && rf_we_o && !mem_we_o, "R2", "restore strobes",
                        32'({mem_re_o, rf_we_o, mem_we_o}), 6);
                    chk(rf_wdata_o == e_data, "R5", "restore data",
                        32'(rf_wdata_o), 32'(e_data));
                end
                @(negedge clk);
            end
            start_i = 1'b0;
            chk(done_o == 1'b1 && !busy_o, "R6", "done after n cycles",
                32'({done_o, busy_o}), 2);
            chk(sp_o == cur, "R3", "final pointer", 32'(sp_o), 32'(cur));
        end
        @(negedge clk);
        chk(done_o == 1'b0 && !busy_o, "R8", "done single pulse",
            32'({done_o, busy_o}), 0);
        chk(sp_o == cur, "R3", "pointer held", 32'(sp_o), 32'(cur));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) bmem[i] = 16'($urandom);
        for (int i = 0; i < 16; i++) begin
            wreg[i] = 16'($urandom);
            breg[i] = 8'($urandom);
        end
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(!busy_o && !done_o, "R9", "reset flags", 32'({busy_o, done_o}), 0);
        chk(!(mem_we_o || mem_re_o || rf_we_o), "R9", "reset strobes",
            32'({mem_we_o, mem_re_o, rf_we_o}), 0);
        chk(sp_o == 16'h0, "R9", "reset pointer", 32'(sp_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_op(1'b0, 1'b1, 1'b0, 8'hA5, 16'h0180, 1'b0); // R1 word save
        run_op(1'b1, 1'b1, 1'b0, 8'hA5, 16'h0178, 1'b0); // R2 word restore
        run_op(1'b0, 1'b0, 1'b1, 8'hFF, 16'h01C0, 1'b0); // R4 R5 byte save, upper bank
        run_op(1'b1, 1'b0, 1'b1, 8'h3C, 16'h0160, 1'b0); // R5 byte restore, dirty upper bytes
        run_op(1'b0, 1'b1, 1'b1, 8'h00, 16'h0150, 1'b0); // R7 empty save
        run_op(1'b1, 1'b0, 1'b0, 8'h00, 16'h0152, 1'b0); // R7 empty restore
        run_op(1'b0, 1'b1, 1'b0, 8'h80, 16'h0140, 1'b0); // R6 single top bit
        run_op(1'b1, 1'b1, 1'b1, 8'h01, 16'h0140, 1'b0); // R6 single bottom bit
        run_op(1'b0, 1'b1, 1'b0, 8'h81, 16'h01A0, 1'b1); // R8 start while busy
        run_op(1'b1, 1'b0, 1'b0, 8'h66, 16'h0130, 1'b1); // R8 start while busy

        for (int t = 0; t < 40; t++) begin
            run_op(1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom),
                   16'h0140 + {7'd0, 8'($urandom_range(0, 63)), 1'b0}, 1'b0);
        end

        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule